// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This block performs a complete task switch in hardware once it is handed the selector of the incoming task's state segment. It first writes the running task's architectural registers into the outgoing state segment. It then points the task register at the new selector and reads that selector's two-word descriptor from the global table. It checks the descriptor type and, if the type is valid, reads the incoming image back into the register file. That image covers the general registers, the segment registers, flags, the instruction pointer, the local-table selector and the page-root register. Execution of the new task is signalled by a one-cycle completion pulse.

Every transfer moves one 32-bit word over a simple request/acknowledge memory port. Each word position in a state segment is fixed, so the register index and the memory offset are the same number. The register file outside the block supplies data through a save strobe and accepts data through a load strobe. A request made while the processor runs in the extended 64-bit mode is refused at once with a fault pulse.

Top module: `task_switch_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `mem_req_o`, `done_o` and `fault_o` are low, `tr_sel_o` equals `TR_SEL_RST` (default 16'h0028) and `tr_base_o` equals `TR_BASE_RST` (default 32'h100).
- R2: An accepted switch first issues NSAVE = NGPR+NSEG+2 word writes, for k = 0 to NSAVE-1 in ascending order. Write k goes to `tr_base_o + 4*k` and carries register k of the register file, presented on `rf_idx_o` with `rf_save_o` high. Register k is: k = 0..NGPR-1 general, the next NSEG segment registers, then flags at NGPR+NSEG and the instruction pointer at NGPR+NSEG+1.
- R3: After the last save write, `tr_sel_o` takes the new selector before any descriptor read. The descriptor is then read as two words: word 0 at `gdt_base_i + 8*sel[15:3]` and word 1 at the next word address.
- R4: Descriptor word 0 is the segment base and bits [3:0] of word 1 are the type. If the type differs from `TSS_TYPE` (default 4'h9), the block emits a one-cycle `fault_o` after the second descriptor word. It performs no load and leaves `tr_base_o` unchanged, while `tr_sel_o` keeps the new selector.
- R5: With a valid type, `tr_base_o` becomes the descriptor base. Then NLOAD = NSAVE+2 word reads from `base + 4*k` follow in ascending k. Each is delivered with `rf_load_o` high, `rf_idx_o` = k and `rf_wdata_o` equal to the read word in its acknowledge cycle. The local-table selector is at k = NSAVE and the page root at k = NSAVE+1.
- R6: `done_o` pulses for exactly one cycle, in the cycle after the final load acknowledge. `busy_o` is high from the cycle after acceptance through the done or fault cycle.
- R7: A request stays high with unchanged address, direction and data until `mem_ack_i`. Exactly one word moves per cycle with `mem_req_o` and `mem_ack_i` both high, and any number of wait cycles is tolerated.
- R8: A start with `long_mode_i` high produces a one-cycle `fault_o` in the next cycle. It performs no memory access and leaves the task register unchanged.
- R9: The stack selector/pointer words of the three privilege levels, at word offsets NLOAD to NLOAD+5 of a state segment, are neither written nor read.
- R10: `start_i` is ignored while a switch is in progress, including the final load acknowledge cycle and the done/fault cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a task switch (sampled when idle) |
| new_sel_i | input | 16 | Selector of the incoming state segment |
| long_mode_i | input | 1 | Extended 64-bit mode active; a start is refused |
| gdt_base_i | input | 32 | Base address of the global descriptor table |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Acknowledge of the current request |
| rf_idx_o | output | IDX_W | Register index for save or load |
| rf_save_o | output | 1 | Register file read strobe during save |
| rf_rdata_i | input | 32 | Register value for index `rf_idx_o` |
| rf_load_o | output | 1 | Register file write strobe |
| rf_wdata_o | output | 32 | Value to write into register `rf_idx_o` |
| tr_sel_o | output | 16 | Task register selector |
| tr_base_o | output | 32 | Task register base address |
| busy_o | output | 1 | Switch in progress |
| done_o | output | 1 | One-cycle pulse: new task begins |
| fault_o | output | 1 | One-cycle pulse: switch refused or aborted |

## Verification
Two events can share a clock edge: a fresh start request and the acknowledge that completes the last load of the running switch. The bench raises `start_i` in exactly the cycle where it acknowledges the final load word. It then checks, every cycle, that `busy_o` falls after the single done pulse and that no second save sequence begins. A behavioural model predicts each transfer, the task register contents and the end pulse. A descriptor of the wrong type, and a start in 64-bit mode, are checked to end in fault with the register file and base untouched.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int WORD_W     = 32;
  localparam int SEL_W      = 16;
  localparam int DESC_WORDS = 2;
  localparam int TYPE_W     = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_TRLD,
    ST_DESC,
    ST_LOAD,
    ST_DONE,
    ST_FAULT
  } tsw_state_e;

  // byte address of word slot k of a state segment
  function automatic logic [WORD_W-1:0] slot_addr(input logic [WORD_W-1:0] base,
                                                 input int unsigned k);
    return base + WORD_W'(k * 4);
  endfunction

  // byte address of descriptor word w for a selector (8-byte entries)
  function automatic logic [WORD_W-1:0] desc_addr(input logic [WORD_W-1:0] gdt,
                                                 input logic [SEL_W-1:0] sel,
                                                 input int unsigned w);
    logic [WORD_W-1:0] ofs;
    ofs = WORD_W'(sel >> 3) << 3;
    return gdt + ofs + WORD_W'(w * 4);
  endfunction
endpackage

// File: rtl/tsw_fsm.sv
module tsw_fsm
  import tsw_pkg::*;
#(
  parameter int NSAVE = 16,
  parameter int NLOAD = 18,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             long_mode_i,
  input  logic             xfer_i,
  input  logic             desc_ok_i,
  output tsw_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             accept_o,
  output logic             desc_pass_o
);
  localparam logic [IDX_W-1:0] SAVE_LAST = IDX_W'(NSAVE - 1);
  localparam logic [IDX_W-1:0] LOAD_LAST = IDX_W'(NLOAD - 1);
  localparam logic [IDX_W-1:0] DESC_LAST = IDX_W'(DESC_WORDS - 1);

  tsw_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign accept_o    = (st_q == ST_IDLE) && start_i && !long_mode_i;
  assign desc_pass_o = (st_q == ST_DESC) && xfer_i && (idx_q == DESC_LAST) && desc_ok_i;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      ST_IDLE: if (start_i) begin
        idx_d = '0;
        st_d  = long_mode_i ? ST_FAULT : ST_SAVE;
      end
      ST_SAVE: if (xfer_i) begin
        if (idx_q == SAVE_LAST) begin
          st_d  = ST_TRLD;
          idx_d = '0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_TRLD: st_d = ST_DESC;
      ST_DESC: if (xfer_i) begin
        if (idx_q == DESC_LAST) begin
          idx_d = '0;
          st_d  = desc_ok_i ? ST_LOAD : ST_FAULT;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_LOAD: if (xfer_i) begin
        if (idx_q == LOAD_LAST) begin
          st_d  = ST_DONE;
          idx_d = '0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign state_o = st_q;
  assign idx_o   = idx_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> (st_q != ST_DONE)); // R6
endmodule

// File: rtl/tsw_desc.sv
module tsw_desc
  import tsw_pkg::*;
#(
  parameter logic [TYPE_W-1:0] TSS_TYPE = 4'h9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              cap_base_i,
  input  logic              cap_attr_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] base_o,
  output logic              type_ok_c_o,
  output logic              type_ok_q_o
);
  logic [WORD_W-1:0] base_q;
  logic              ok_q;

  assign type_ok_c_o = (rdata_i[TYPE_W-1:0] == TSS_TYPE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ok_q   <= 1'b0;
    end else begin
      if (cap_base_i) base_q <= rdata_i;
      if (clear_i)         ok_q <= 1'b0;
      else if (cap_attr_i) ok_q <= type_ok_c_o;
    end
  end

  assign base_o      = base_q;
  assign type_ok_q_o = ok_q;
endmodule

// File: rtl/tsw_treg.sv
module tsw_treg
  import tsw_pkg::*;
#(
  parameter logic [SEL_W-1:0]  TR_SEL_RST  = 16'h0028,
  parameter logic [WORD_W-1:0] TR_BASE_RST = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              sel_load_i,
  input  logic              base_load_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic              desc_phase_i,
  output logic [SEL_W-1:0]  tr_sel_o,
  output logic [WORD_W-1:0] tr_base_o
);
  logic [SEL_W-1:0]  pend_q, sel_q;
  logic [WORD_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= TR_SEL_RST;
      sel_q  <= TR_SEL_RST;
      base_q <= TR_BASE_RST;
    end else begin
      if (accept_i)    pend_q <= sel_i;
      if (sel_load_i)  sel_q  <= pend_q;
      if (base_load_i) base_q <= base_i;
    end
  end

  assign tr_sel_o  = sel_q;
  assign tr_base_o = base_q;

  AST_SEL_BEFORE_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    desc_phase_i |-> (sel_q == pend_q)); // R3
endmodule

// File: rtl/task_switch_seq.sv
module task_switch_seq
  import tsw_pkg::*;
#(
  parameter int                NGPR        = 8,
  parameter int                NSEG        = 6,
  parameter logic [15:0]       TR_SEL_RST  = 16'h0028,
  parameter logic [31:0]       TR_BASE_RST = 32'h0000_0100,
  parameter logic [3:0]        TSS_TYPE    = 4'h9,
  localparam int               NSAVE       = NGPR + NSEG + 2,
  localparam int               NLOAD       = NSAVE + 2,
  localparam int               IDX_W       = $clog2(NLOAD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [15:0]      new_sel_i,
  input  logic             long_mode_i,
  input  logic [31:0]      gdt_base_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [31:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i,
  input  logic             mem_ack_i,
  output logic [IDX_W-1:0] rf_idx_o,
  output logic             rf_save_o,
  input  logic [31:0]      rf_rdata_i,
  output logic             rf_load_o,
  output logic [31:0]      rf_wdata_o,
  output logic [15:0]      tr_sel_o,
  output logic [31:0]      tr_base_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o
);
  tsw_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic              xfer, accept, desc_pass, desc_ok_c, desc_ok_q;
  logic              cap_base, cap_attr;
  logic [WORD_W-1:0] desc_base;

  // named internal events
  assign xfer     = mem_req_o && mem_ack_i;
  assign cap_base = (state == ST_DESC) && xfer && (idx == '0);
  assign cap_attr = (state == ST_DESC) && xfer && (idx == IDX_W'(DESC_WORDS - 1));

  tsw_fsm #(.NSAVE(NSAVE), .NLOAD(NLOAD), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_mode_i(long_mode_i),
    .xfer_i(xfer), .desc_ok_i(desc_ok_c), .state_o(state), .idx_o(idx),
    .accept_o(accept), .desc_pass_o(desc_pass)
  );

  tsw_desc #(.TSS_TYPE(TSS_TYPE)) u_desc (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .cap_base_i(cap_base),
    .cap_attr_i(cap_attr), .rdata_i(mem_rdata_i), .base_o(desc_base),
    .type_ok_c_o(desc_ok_c), .type_ok_q_o(desc_ok_q)
  );

  tsw_treg #(.TR_SEL_RST(TR_SEL_RST), .TR_BASE_RST(TR_BASE_RST)) u_treg (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .sel_i(new_sel_i),
    .sel_load_i(state == ST_TRLD), .base_load_i(desc_pass), .base_i(desc_base),
    .desc_phase_i(state == ST_DESC), .tr_sel_o(tr_sel_o), .tr_base_o(tr_base_o)
  );

  // memory port: save and load both address the segment held in the task register
  assign mem_req_o = (state == ST_SAVE) || (state == ST_DESC) || (state == ST_LOAD);
  assign mem_we_o  = (state == ST_SAVE);

  always_comb begin
    case (state)
      ST_DESC: mem_addr_o = desc_addr(gdt_base_i, tr_sel_o, 32'(idx));
      ST_SAVE,
      ST_LOAD: mem_addr_o = slot_addr(tr_base_o, 32'(idx));
      default: mem_addr_o = tr_base_o;
    endcase
  end

  assign mem_wdata_o = rf_rdata_i;
  assign rf_idx_o    = idx;
  assign rf_save_o   = (state == ST_SAVE);
  assign rf_load_o   = (state == ST_LOAD) && mem_ack_i;
  assign rf_wdata_o  = mem_rdata_i;

  assign busy_o  = (state != ST_IDLE);
  assign done_o  = (state == ST_DONE);
  assign fault_o = (state == ST_FAULT);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R7

  AST_LONG_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && long_mode_i) |=> (fault_o && !mem_req_o)); // R8

  AST_LOAD_NEEDS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_load_o |-> desc_ok_q); // R4

  AST_NO_STACK_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && (state != ST_DESC)) |-> ((mem_addr_o - tr_base_o) < 32'(NLOAD * 4))); // R9

  AST_FAULT_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && busy_o) |-> $stable(tr_base_o)); // R4
endmodule

// File: tb/task_switch_seq_test.sv
module task_switch_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int NL = 18;
  localparam logic [31:0] GDT = 32'h800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] new_sel_i = '0;
  logic long_mode_i = 1'b0;
  logic mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic [4:0] rf_idx_o;
  logic rf_save_o, rf_load_o;
  logic [31:0] rf_rdata_i, rf_wdata_o, tr_base_o;
  logic [15:0] tr_sel_o;
  logic busy_o, done_o, fault_o;

  int checks = 0, fails = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] rf_m [0:31];
  logic [31:0] exp_rf [0:31];
  logic [31:0] q_addr[$], q_data[$];
  bit q_we[$], q_ld[$];
  int q_idx[$], q_end[$];
  logic [15:0] q_sel[$];
  logic [15:0] m_sel = 16'h0028;
  logic [31:0] m_base = 32'h100;
  bit m_busy = 0, closing = 0;
  int pend_end = 0, wait_pat = 0, wcnt = 0;
  logic st_s = 0, lm_s = 0;
  logic [15:0] sel_s = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  task_switch_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .new_sel_i(new_sel_i),
    .long_mode_i(long_mode_i), .gdt_base_i(GDT), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i), .rf_idx_o(rf_idx_o),
    .rf_save_o(rf_save_o), .rf_rdata_i(rf_rdata_i), .rf_load_o(rf_load_o),
    .rf_wdata_o(rf_wdata_o), .tr_sel_o(tr_sel_o), .tr_base_o(tr_base_o),
    .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o)
  );

  assign rf_rdata_i = rf_m[rf_idx_o];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] img(input logic [31:0] base, input int k);
    return 32'h1000_0000 | (base << 8) | 32'(k);
  endfunction
  function automatic logic [31:0] stk(input logic [31:0] base, input int k);
    return 32'h5700_0000 | (base << 8) | 32'(k);
  endfunction

  // register file written through the block's load strobe
  always @(posedge clk) begin
    if (rf_load_o) rf_m[rf_idx_o] <= rf_wdata_o;
    st_s  <= start_i;
    lm_s  <= long_mode_i;
    sel_s <= new_sel_i;
  end

  // reference model, compared every cycle
  always @(negedge clk) begin
    bit acc, lacc, nacc, e_done, e_fault;
    if (rst_n) begin
      acc  = st_s && !m_busy;   // R10: start while busy is dropped
      lacc = acc && lm_s;
      nacc = acc && !lm_s;
      if (closing) begin m_busy = 0; closing = 0; end
      e_done  = (pend_end == 1);
      e_fault = (pend_end == 2) || lacc;
      if (pend_end != 0) closing = 1;
      pend_end = 0;
      if (lacc) begin m_busy = 1; closing = 1; end
      if (nacc) begin
        logic [31:0] w0, w1, da;
        bit ok;
        m_busy = 1;
        for (int k = 0; k < NS; k++) begin
          q_addr.push_back(m_base + 32'(4*k)); q_data.push_back(rf_m[k]);
          q_we.push_back(1); q_ld.push_back(0); q_idx.push_back(k);
          q_end.push_back(0); q_sel.push_back(m_sel);
        end
        da = GDT + {16'h0, sel_s[15:3], 3'b000};
        w0 = mem[da[11:2]]; w1 = mem[da[11:2] + 10'd1];
        ok = (w1[3:0] == 4'h9);
        for (int k = 0; k < 2; k++) begin
          q_addr.push_back(da + 32'(4*k)); q_data.push_back(k == 0 ? w0 : w1);
          q_we.push_back(0); q_ld.push_back(0); q_idx.push_back(k);
          q_end.push_back((k == 1 && !ok) ? 2 : 0); q_sel.push_back(sel_s);
        end
        m_sel = sel_s;
        if (ok) begin
          m_base = w0;
          for (int k = 0; k < NL; k++) begin
            logic [31:0] a;
            a = w0 + 32'(4*k);
            exp_rf[k] = mem[a[11:2]];
            q_addr.push_back(a); q_data.push_back(mem[a[11:2]]);
            q_we.push_back(0); q_ld.push_back(1); q_idx.push_back(k);
            q_end.push_back(k == NL-1 ? 1 : 0); q_sel.push_back(sel_s);
          end
        end
      end
      chk(busy_o == m_busy, "R6 busy", 32'(busy_o), 32'(m_busy));
      chk(done_o == e_done, "R6 done pulse", 32'(done_o), 32'(e_done));
      chk(fault_o == e_fault, "R4/R8 fault pulse", 32'(fault_o), 32'(e_fault));
      if (mem_req_o) begin
        if (wcnt >= wait_pat) begin
          wcnt = 0;
          if (q_addr.size() == 0) begin
            chk(0, "R2 unexpected transfer", mem_addr_o, 32'hFFFF_FFFF);
            mem_ack_i = 1'b0;
          end else begin
            logic [31:0] ea, ed; bit ew, eld; int ei, ee; logic [15:0] es;
            ea = q_addr.pop_front(); ed = q_data.pop_front(); ew = q_we.pop_front();
            eld = q_ld.pop_front(); ei = q_idx.pop_front(); ee = q_end.pop_front();
            es = q_sel.pop_front();
            chk(mem_addr_o == ea, "R2/R3/R5 address order", mem_addr_o, ea);
            chk(mem_we_o == ew, "R7 direction", 32'(mem_we_o), 32'(ew));
            chk(tr_sel_o == es, "R3 task selector timing", 32'(tr_sel_o), 32'(es));
            chk(mem_addr_o[31:12] == 0, "R9 address range", mem_addr_o, 32'h0);
            if (ew) begin
              chk(mem_wdata_o == ed, "R2 saved word", mem_wdata_o, ed);
              chk(rf_save_o && (32'(rf_idx_o) == 32'(ei)), "R2 save index", 32'(rf_idx_o), 32'(ei));
              mem[mem_addr_o[11:2]] = mem_wdata_o;
            end
            mem_rdata_i = mem[mem_addr_o[11:2]];
            mem_ack_i = 1'b1;
            pend_end = ee;
            #1;
            chk(rf_load_o == eld, "R5 load strobe", 32'(rf_load_o), 32'(eld));
            if (eld) begin
              chk(32'(rf_idx_o) == 32'(ei), "R5 load index", 32'(rf_idx_o), 32'(ei));
              chk(rf_wdata_o == ed, "R5 load data", rf_wdata_o, ed);
            end
          end
        end else begin
          wcnt++;
          mem_ack_i = 1'b0;
        end
      end else begin
        wcnt = 0;
        mem_ack_i = 1'b0;
      end
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy_o);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_switch(input logic [15:0] sel, input bit lm);
    @(negedge clk);
    start_i = 1'b1; new_sel_i = sel; long_mode_i = lm;
    @(negedge clk);
    start_i = 1'b0; long_mode_i = 1'b0;
    wait_idle();
  endtask

  task automatic end_checks(input logic [31:0] old_base, input bit loaded);
    chk(tr_sel_o == m_sel, "R3 final selector", 32'(tr_sel_o), 32'(m_sel));
    chk(tr_base_o == m_base, "R4/R5 final base", tr_base_o, m_base);
    chk(q_addr.size() == 0, "R5 all transfers made", 32'(q_addr.size()), 32'h0);
    for (int j = NL; j < NL + 6; j++) begin
      chk(mem[old_base[11:2] + 10'(j)] == stk(old_base, j), "R9 outgoing stack slot",
          mem[old_base[11:2] + 10'(j)], stk(old_base, j));
      chk(mem[m_base[11:2] + 10'(j)] == stk(m_base, j), "R9 incoming stack slot",
          mem[m_base[11:2] + 10'(j)], stk(m_base, j));
    end
    if (loaded)
      for (int k = 0; k < NL; k++)
        chk(rf_m[k] == exp_rf[k], "R5 register file image", rf_m[k], exp_rf[k]);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    for (int b = 1; b <= 4; b++)
      for (int k = 0; k < NL + 6; k++)
        mem[(b * 64) + k] = (k < NL) ? img(32'(b * 256), k) : stk(32'(b * 256), k);
    mem[GDT[11:2] + 2] = 32'h200; mem[GDT[11:2] + 3] = 32'h0000_0089;
    mem[GDT[11:2] + 4] = 32'h300; mem[GDT[11:2] + 5] = 32'h0000_0089;
    mem[GDT[11:2] + 6] = 32'h400; mem[GDT[11:2] + 7] = 32'h0000_0082;
    for (int k = 0; k < 32; k++) rf_m[k] = 32'hA000_0000 | 32'(k);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !mem_req_o && !done_o && !fault_o, "R1 idle outputs",
        {busy_o, mem_req_o, done_o, fault_o}, 32'h0);
    chk(tr_sel_o == 16'h0028, "R1 selector reset", 32'(tr_sel_o), 32'h28);
    chk(tr_base_o == 32'h100, "R1 base reset", tr_base_o, 32'h100);

    // R2 R3 R5 R7: zero-wait switch
    wait_pat = 0;
    do_switch(16'h0008, 1'b0);
    end_checks(32'h100, 1);
    // R7: wait states
    wait_pat = 2;
    do_switch(16'h0010, 1'b0);
    end_checks(32'h200, 1);
    // R8: refused in extended mode
    wait_pat = 0;
    do_switch(16'h0008, 1'b1);
    chk(tr_sel_o == 16'h0010 && tr_base_o == 32'h300, "R8 task register kept",
        tr_base_o, 32'h300);
    // R4: wrong descriptor type
    wait_pat = 1;
    do_switch(16'h0018, 1'b0);
    end_checks(32'h300, 0);
    chk(rf_m[NS] == exp_rf[NS], "R4 no load on fault", rf_m[NS], exp_rf[NS]);
    // R10: start coinciding with the final load acknowledge
    wait_pat = 0;
    @(negedge clk);
    start_i = 1'b1; new_sel_i = 16'h0008;
    @(negedge clk);
    start_i = 1'b0;
    while (!(mem_req_o && !mem_we_o && mem_addr_o == 32'h200 + 32'(4*(NL-1)))) @(negedge clk);
    start_i = 1'b1; new_sel_i = 16'h0010;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    end_checks(32'h300, 1);
    repeat (5) @(negedge clk);
    chk(!busy_o && tr_sel_o == 16'h0008, "R10 second start ignored", 32'(tr_sel_o), 32'h8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R6 actual=busy expected=idle");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule